// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block sits on a two-wire bus as a target device and acts as byte-wide storage behind a 16-bit address pointer. It oversamples the bus clock and data lines with the system clock. From those samples it finds bus START and STOP conditions and shifts in the device address byte. When the upper five address bits match a fixed prefix and the two low bits match the strap inputs, it acknowledges. The last bit of the address byte selects the direction.

In a write transfer, the first two bytes after the address set the pointer, most significant byte first. Any further bytes are stored at the pointer, and the pointer advances after each one. A write that carries only the two pointer bytes, followed by a repeated START with a read address, returns data from the new pointer. A read transfer shifts out the byte at the pointer, MSB first, and advances the pointer after each byte. The block stops driving the bus when the controller answers a byte with NACK. The storage depth is a parameter. Only the low log2(DEPTH) bits of the pointer index the array.

Top module: `i2c_serial_mem`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `sda_oe` is 0 (the line is released).
- R2: After a START (data falling while clock is high), an address byte whose upper seven bits equal {5'b10100, strap_i} is acknowledged by `sda_oe`=1 during the ninth clock high phase. `sda_oe` only rises while the clock is low.
- R3: An address byte with any other prefix gets no acknowledge. The block then leaves the line released for every later clock until the next START or STOP.
- R4: With address LSB 0, the first data byte after the address loads pointer bits 15:8 and the second loads bits 7:0. Both are acknowledged.
- R5: Each further write byte is acknowledged, stored at the pointer, and the pointer then increments by one.
- R6: With address LSB 1, the block drives the byte at the pointer MSB first (`sda_oe`=1 for a 0 bit) and increments the pointer after each byte. A new read without a pointer load continues from the pointer left by the last transfer.
- R7: A write carrying only the two pointer bytes, followed by a repeated START and a read address, returns data starting at that pointer.
- R8: When the controller answers a read byte with NACK (data high in the ninth clock), the block releases the line and drives nothing on further clocks until a START or STOP.
- R9: A STOP (data rising while clock is high) returns the block to idle with the line released from any state. A later transfer is then handled normally.
- R10: A strap value different from the address bits 2:1 of the address byte leaves the device silent, so four devices can share one bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Device select straps, compared with address bits 2:1 of the address byte |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The checker watches several rules on every cycle. `sda_oe` never rises while the synchronised bus clock is high. START and STOP always leave the line released, and STOP also returns the block to idle. Every stored byte coincides with an acknowledge. A controller NACK ends driving at once. The directed scenarios are the only way to show the data path. They cover pointer loading order, stored and returned byte values, pointer increments across transfers, the dummy-write-then-read sequence, and silence toward mismatched prefixes and straps.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_END,
    ST_DEV_ACK,
    ST_WR,
    ST_WR_END,
    ST_WR_ACK,
    ST_RD,
    ST_RD_MACK,
    ST_RD_LOAD
  } eng_state_e;

endpackage

// File: rtl/i2cmem_rstsync.sv
module i2cmem_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] rq;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      rq <= '0;
    end else begin
      rq <= {rq[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = rq[STAGES-1];

endmodule

// File: rtl/i2cmem_busmon.sv
module i2cmem_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;

  // bus idles high, so the sampling chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges count as conditions only while clock held high on both samples
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store
  import i2cmem_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [BYTE_W-1:0] rdata
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr[AW-1:0]] <= wdata;
    end
  end

  assign rdata = mem[raddr[AW-1:0]];

  generate
    if (AW < PTR_W) begin : g_alias
      // upper pointer bits alias onto the smaller array
      logic unused_hi;
      assign unused_hi = ^{waddr[PTR_W-1:AW], raddr[PTR_W-1:AW]};
    end
  endgenerate

endmodule

// File: rtl/i2cmem_engine.sv
module i2cmem_engine
  import i2cmem_pkg::*;
#(
  parameter int                STRAP_W    = 2,
  parameter logic [6-STRAP_W:0] DEV_PREFIX = 5'b10100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rdata,
  output logic               sda_oe,
  output logic               we,
  output logic [PTR_W-1:0]   waddr,
  output logic [BYTE_W-1:0]  wdata,
  output logic [PTR_W-1:0]   raddr,
  output eng_state_e         state
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_state_e        st_q,   st_n;
  logic [CNT_W-1:0]  cnt_q,  cnt_n;
  logic [BYTE_W-1:0] shr_q,  shr_n;
  logic [BYTE_W-1:0] txd_q,  txd_n;
  logic [PTR_W-1:0]  ptr_q,  ptr_n;
  logic [1:0]        widx_q, widx_n;
  logic              rw_q,   rw_n;
  logic              oe_q,   oe_n;
  logic              we_c;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    shr_n  = shr_q;
    txd_n  = txd_q;
    ptr_n  = ptr_q;
    widx_n = widx_q;
    rw_n   = rw_q;
    oe_n   = oe_q;
    we_c   = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n   = ST_DEV;
      cnt_n  = '0;
      oe_n   = 1'b0;
      widx_n = 2'd0;
    end else begin
      case (st_q)
        ST_IDLE: ;
        ST_DEV: begin
          if (scl_rise) begin
            shr_n = {shr_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) st_n = ST_DEV_END;
          end
        end
        ST_DEV_END: begin
          if (scl_fall) begin
            if (shr_q[BYTE_W-1:1] == {DEV_PREFIX, strap_i}) begin
              oe_n = 1'b1;
              rw_n = shr_q[0];
              st_n = ST_DEV_ACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              txd_n = rdata;
              oe_n  = ~rdata[BYTE_W-1];
              st_n  = ST_RD;
            end else begin
              oe_n = 1'b0;
              st_n = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shr_n = {shr_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) st_n = ST_WR_END;
          end
        end
        ST_WR_END: begin
          if (scl_fall) begin
            oe_n = 1'b1;
            st_n = ST_WR_ACK;
            case (widx_q)
              2'd0: begin
                ptr_n[PTR_W-1:BYTE_W] = shr_q;
                widx_n = 2'd1;
              end
              2'd1: begin
                ptr_n[BYTE_W-1:0] = shr_q;
                widx_n = 2'd2;
              end
              default: begin
                we_c  = 1'b1;
                ptr_n = ptr_q + 1'b1;
              end
            endcase
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            st_n  = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_n  = 1'b0;
              ptr_n = ptr_q + 1'b1;
              st_n  = ST_RD_MACK;
            end else begin
              cnt_n = cnt_q + 1'b1;
              txd_n = {txd_q[BYTE_W-2:0], 1'b0};
              oe_n  = ~txd_q[BYTE_W-2];
            end
          end
        end
        ST_RD_MACK: begin
          if (scl_rise) begin
            st_n = sda_s ? ST_IDLE : ST_RD_LOAD;
          end
        end
        ST_RD_LOAD: begin
          if (scl_fall) begin
            txd_n = rdata;
            oe_n  = ~rdata[BYTE_W-1];
            cnt_n = '0;
            st_n  = ST_RD;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      shr_q  <= '0;
      txd_q  <= '0;
      ptr_q  <= '0;
      widx_q <= 2'd0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      shr_q  <= shr_n;
      txd_q  <= txd_n;
      ptr_q  <= ptr_n;
      widx_q <= widx_n;
      rw_q   <= rw_n;
      oe_q   <= oe_n;
    end
  end

  assign sda_oe = oe_q;
  assign we     = we_c;
  assign waddr  = ptr_q;
  assign wdata  = shr_q;
  assign raddr  = ptr_q;
  assign state  = st_q;

endmodule

// File: rtl/i2c_serial_mem.sv
module i2c_serial_mem
  import i2cmem_pkg::*;
#(
  parameter int                 DEPTH      = 256,
  parameter int                 SYNC_STG   = 2,
  parameter int                 STRAP_W    = 2,
  parameter logic [6-STRAP_W:0] DEV_PREFIX = 5'b10100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe
);

  logic              rst_ns;
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              mem_we;
  logic [PTR_W-1:0]  mem_waddr;
  logic [PTR_W-1:0]  mem_raddr;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] mem_rdata;
  eng_state_e        eng_state;

  i2cmem_rstsync #(.STAGES(SYNC_STG)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_ns)
  );

  i2cmem_busmon #(.STAGES(SYNC_STG)) u_mon (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cmem_engine #(
    .STRAP_W    (STRAP_W),
    .DEV_PREFIX (DEV_PREFIX)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .strap_i   (strap_i),
    .rdata     (mem_rdata),
    .sda_oe    (sda_oe),
    .we        (mem_we),
    .waddr     (mem_waddr),
    .wdata     (mem_wdata),
    .raddr     (mem_raddr),
    .state     (eng_state)
  );

  i2cmem_store #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/i2cmem_chk.sv
module i2cmem_chk
  import i2cmem_pkg::*;
(
  input logic       clk,
  input logic       rst_ns,
  input logic       scl_s,
  input logic       sda_s,
  input logic       scl_rise,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       mem_we,
  input eng_state_e eng_state
);

  AST_ACK_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(sda_oe) |-> !scl_s); // R2

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_ns)
    start_det |=> (!sda_oe && eng_state == ST_DEV)); // R2

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_ns)
    (eng_state == ST_IDLE) |-> !sda_oe); // R3

  AST_STORE_ACKED: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_we |=> sda_oe); // R5

  AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_ns)
    (eng_state == ST_RD_MACK && scl_rise && sda_s && !start_det && !stop_det)
      |=> (eng_state == ST_IDLE && !sda_oe)); // R8

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_ns)
    stop_det |=> (eng_state == ST_IDLE && !sda_oe)); // R9

endmodule

bind i2c_serial_mem i2cmem_chk u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .scl_s     (scl_s),
  .sda_s     (sda_s),
  .scl_rise  (scl_rise),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .mem_we    (mem_we),
  .eng_state (eng_state)
);

// File: tb/tb_i2c_serial_mem.sv
module tb_i2c_serial_mem;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;     // system clocks per quarter bus bit
  localparam logic [7:0] WR_ADR = 8'hA2;  // prefix 10100, strap 01, write
  localparam logic [7:0] RD_ADR = 8'hA3;

  logic clk;
  logic rst_n;
  logic scl_m;
  logic sda_m;
  logic sda_oe;
  logic sda_bus;
  logic [1:0] strap;

  int checks;
  int errors;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_serial_mem dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .strap_i (strap),
    .sda_oe  (sda_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = sda_bus;
    wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_bus;
      wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = nack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    wq(2);
    rst_n = 1'b1;
    wq(1);
    chk(sda_oe == 1'b0, "R1 oe after release", sda_oe, 0);
    wq(4);
  endtask

  task automatic t_nomatch(input logic [7:0] adr, input string tag);
    logic a;
    bus_start();
    send_byte(adr, a);
    chk(a == 1'b1, tag, a, 1);
    send_byte(8'h00, a);
    chk(a == 1'b1, tag, a, 1);
    chk(sda_oe == 1'b0, tag, sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_write();
    logic a;
    logic [7:0] d [5] = '{8'h3C, 8'hA5, 8'h0F, 8'h81, 8'h7E};
    bus_start();
    send_byte(WR_ADR, a);
    chk(a == 1'b0, "R2 address ack", a, 0);
    send_byte(8'h12, a);
    chk(a == 1'b0, "R4 pointer high ack", a, 0);
    send_byte(8'h34, a);
    chk(a == 1'b0, "R4 pointer low ack", a, 0);
    for (int i = 0; i < 5; i++) begin
      send_byte(d[i], a);
      chk(a == 1'b0, "R5 data ack", a, 0);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
  endtask

  task automatic t_dummy_read();
    logic a;
    logic [7:0] b;
    logic [7:0] e [4] = '{8'h3C, 8'hA5, 8'h0F, 8'h81};
    bus_start();
    send_byte(WR_ADR, a);
    send_byte(8'h12, a);
    send_byte(8'h34, a);
    chk(a == 1'b0, "R7 pointer ack", a, 0);
    bus_start();
    send_byte(RD_ADR, a);
    chk(a == 1'b0, "R7 read address ack", a, 0);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i == 3, b);
      chk(b == e[i], "R6 R7 read data", b, e[i]);
    end
    chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
    recv_byte(1'b1, b);
    chk(b == 8'hFF, "R8 silent after nack", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(RD_ADR, a);
    chk(a == 1'b0, "R6 current read ack", a, 0);
    recv_byte(1'b1, b);
    chk(b == 8'h7E, "R6 pointer continues", b, 8'h7E);
    bus_stop();
  endtask

  task automatic t_stop_abort();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(WR_ADR, a);
    send_byte(8'h00, a);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 oe after abort", sda_oe, 0);
    bus_start();
    send_byte(WR_ADR, a);
    chk(a == 1'b0, "R9 ack after abort", a, 0);
    send_byte(8'h12, a);
    send_byte(8'h36, a);
    bus_start();
    send_byte(RD_ADR, a);
    recv_byte(1'b1, b);
    chk(b == 8'h0F, "R9 R4 data after abort", b, 8'h0F);
    bus_stop();
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    scl_m  = 1'b1;
    sda_m  = 1'b1;
    strap  = 2'b01;
    wq(3);
    t_reset();
    t_nomatch(8'hA0, "R10 other strap silent");
    t_nomatch(8'hB2, "R3 other prefix silent");
    t_write();
    t_dummy_read();
    t_current_read();
    t_stop_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule